// File: doc/BRIEF.md
# Event Timer with Single Comparator Channel

This block is a 64-bit up-counter paired with one comparator channel. Software reaches it through a flat 32-bit register port with a combinational read path. The counter advances once per clock while a run bit is set. When the counter reaches the programmed target, the channel records the event in a status bit. It can also drive an active-high interrupt line.

The channel runs in one-shot or periodic mode. In periodic mode each match moves the target forward by a programmed period, so the comparator register always shows the next firing point. The 64-bit target and period are written as two 32-bit halves. An arm bit in the channel configuration chooses for each half whether a write in periodic mode loads the target as well as the period, or only the period. The arm bit clears itself after every comparator half write.

The interrupt line either pulses once per match (edge signalling) or holds until software writes 1 to the status bit (level signalling).

Register map (byte offsets on `bus_addr`):

| Offset | Access | Contents |
|---|---|---|
| 0x04 | read/write | bit 0 is the counter run enable |
| 0x08 | read, write-1-to-clear | bit 0 is the match status |
| 0x10 | read/write | bit 0 interrupt enable; bit 1 level signalling (0 means edge); bit 2 periodic (0 means one-shot); bit 3 arm |
| 0x18 | read only | counter bits 31:0 |
| 0x1C | read only | counter bits 63:32 |
| 0x20 | read/write | comparator bits 31:0 (reads return the target) |
| 0x24 | read/write | comparator bits 63:32 (reads return the target) |

Top module: `evt_timer`

## Requirements
- R1: When bit 0 at offset 0x04 is 1, the counter increments by one on every clock. When that bit is 0, the counter holds its value.
- R2: Reads at 0x18 and 0x1C return the current counter halves in every mode. All registers read zero after reset.
- R3: A match occurs in a cycle where the counter runs and equals the target. With bit 2 of 0x10 at 0 (one-shot), a match leaves the target unchanged, so the channel does not fire again while the counter keeps counting upward.
- R4: With bit 2 of 0x10 at 1 (periodic), in the cycle after a match the target equals the old target plus the period. Reads at 0x20 and 0x24 return this next target.
- R5: Status bit 0 at 0x08 is set in the cycle after every match, whatever the interrupt enable. Writing 1 clears it and writing 0 leaves it unchanged. A match in the same cycle as a clear wins.
- R6: When interrupt enable (bit 0 of 0x10) is 0, irq_o stays low.
- R7: With bit 1 of 0x10 at 1 (level), irq_o equals status AND interrupt enable. It stays high until status is cleared.
- R8: With bit 1 of 0x10 at 0 (edge), irq_o is high for the one cycle after each enabled match. It does not depend on status.
- R9: A comparator half write loads both the target half and the period half when the arm bit (bit 3 of 0x10) is set or the channel is one-shot. The arm bit reads 0 after any comparator half write. A write that loads the target takes priority over a periodic advance in the same cycle.
- R10: In periodic mode, a comparator half write with the arm bit clear updates only that half of the period. The target is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Active-high channel interrupt |

## Verification
The hardest case to reach is a periodic channel with a period of 1. There the target advances in step with the counter, so a match occurs on every cycle and the edge output stays high continuously. The bench reaches this case in two steps. First it arms the channel and loads a real target. It then writes an unarmed low half of 1, which changes only the period, and lets the channel catch up. A behavioural model tracks every cycle from the register writes. It also covers the cases where a write to the status clear lands next to a match. The bench closes by loading a large high half to show that no match occurs.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;
  localparam int unsigned OFS_GCFG  = 'h04;
  localparam int unsigned OFS_ISTAT = 'h08;
  localparam int unsigned OFS_CCFG  = 'h10;
  localparam int unsigned OFS_CNT   = 'h18;
  localparam int unsigned OFS_CMP   = 'h20;

  typedef struct packed {
    logic arm;
    logic per;
    logic lvl;
    logic ien;
  } ccfg_t;
endpackage

// File: rtl/evt_tmr_counter.sv
module evt_tmr_counter #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (run_i) cnt_n = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_tmr_channel.sv
module evt_tmr_channel #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned BUS_W = 32,
  localparam int unsigned HALVES = CNT_W / BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              periodic_i,
  input  logic [HALVES-1:0] wr_half_i,
  input  logic              ld_tgt_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  tgt_o,
  output logic [CNT_W-1:0]  per_o,
  output logic              match_o
);
  logic [CNT_W-1:0] tgt_q, tgt_n, per_q, per_n;
  logic [CNT_W-1:0] tgt_wr, per_wr;
  logic             tgt_load;

  assign match_o  = run_i && (cnt_i == tgt_q);
  assign tgt_load = ld_tgt_i && (|wr_half_i);

  for (genvar i = 0; i < HALVES; i++) begin : g_half
    assign per_wr[i*BUS_W +: BUS_W] = wr_half_i[i] ? wdata_i : per_q[i*BUS_W +: BUS_W];
    assign tgt_wr[i*BUS_W +: BUS_W] = wr_half_i[i] ? wdata_i : tgt_q[i*BUS_W +: BUS_W];
  end

  always_comb begin
    per_n = per_wr;
    tgt_n = tgt_q;
    if (tgt_load)                    tgt_n = tgt_wr;
    else if (match_o && periodic_i)  tgt_n = tgt_q + per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q <= '0;
      per_q <= '0;
    end else begin
      tgt_q <= tgt_n;
      per_q <= per_n;
    end
  end

  assign tgt_o = tgt_q;
  assign per_o = per_q;
endmodule

// File: rtl/evt_tmr_irq.sv
module evt_tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic ien_i,
  input  logic lvl_i,
  input  logic clr_i,
  output logic stat_o,
  output logic irq_o
);
  logic stat_q, stat_n, pulse_q, pulse_n;

  always_comb begin
    stat_n = stat_q;
    if (match_i)    stat_n = 1'b1;
    else if (clr_i) stat_n = 1'b0;
    pulse_n = match_i && ien_i && !lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      stat_q  <= stat_n;
      pulse_q <= pulse_n;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = lvl_i ? (stat_q && ien_i) : pulse_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq_o
);
  localparam int unsigned HALVES = CNT_W / BUS_W;
  localparam int unsigned STEP   = BUS_W / 8;

  logic [1:0]        rst_sync;
  logic              rst_s;
  logic              run_q, run_n;
  ccfg_t             ccfg_q, ccfg_n;
  logic [HALVES-1:0] wr_half;
  logic              ld_tgt, match, stat, clr;
  logic [CNT_W-1:0]  cnt, tgt, per;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  for (genvar i = 0; i < HALVES; i++) begin : g_dec
    assign wr_half[i] = bus_wr && (bus_addr == ADDR_W'(OFS_CMP + STEP*i));
  end

  assign clr    = bus_wr && (bus_addr == ADDR_W'(OFS_ISTAT)) && bus_wdata[0];
  assign ld_tgt = ccfg_q.arm || !ccfg_q.per;

  always_comb begin
    run_n  = run_q;
    ccfg_n = ccfg_q;
    if (bus_wr && (bus_addr == ADDR_W'(OFS_GCFG))) run_n = bus_wdata[0];
    if (bus_wr && (bus_addr == ADDR_W'(OFS_CCFG))) ccfg_n = ccfg_t'(bus_wdata[3:0]);
    else if (|wr_half)                             ccfg_n.arm = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      run_q  <= 1'b0;
      ccfg_q <= '0;
    end else begin
      run_q  <= run_n;
      ccfg_q <= ccfg_n;
    end
  end

  evt_tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .run_i(run_q), .cnt_o(cnt)
  );

  evt_tmr_channel #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chan (
    .clk(clk), .rst_n(rst_s), .run_i(run_q), .cnt_i(cnt),
    .periodic_i(ccfg_q.per), .wr_half_i(wr_half), .ld_tgt_i(ld_tgt),
    .wdata_i(bus_wdata), .tgt_o(tgt), .per_o(per), .match_o(match)
  );

  evt_tmr_irq u_irq (
    .clk(clk), .rst_n(rst_s), .match_i(match), .ien_i(ccfg_q.ien),
    .lvl_i(ccfg_q.lvl), .clr_i(clr), .stat_o(stat), .irq_o(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_GCFG))  bus_rdata[0]   = run_q;
    if (bus_addr == ADDR_W'(OFS_ISTAT)) bus_rdata[0]   = stat;
    if (bus_addr == ADDR_W'(OFS_CCFG))  bus_rdata[3:0] = ccfg_q;
    for (int i = 0; i < int'(HALVES); i++) begin
      if (bus_addr == ADDR_W'(OFS_CNT + STEP*i)) bus_rdata = cnt[i*BUS_W +: BUS_W];
      if (bus_addr == ADDR_W'(OFS_CMP + STEP*i)) bus_rdata = tgt[i*BUS_W +: BUS_W];
    end
  end
endmodule

// File: rtl/evt_tmr_chk.sv
module evt_tmr_chk
  import evt_tmr_pkg::*;
#(
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned HALVES = 2
) (
  input logic              clk,
  input logic              rst_s,
  input logic              run_q,
  input ccfg_t             ccfg_q,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  tgt,
  input logic [CNT_W-1:0]  per,
  input logic              match,
  input logic              stat,
  input logic              ld_tgt,
  input logic [HALVES-1:0] wr_half,
  input logic              bus_wr,
  input logic              irq_o
);
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    !run_q |=> $stable(cnt)); // R1
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_s)
    run_q |=> (cnt == $past(cnt) + CNT_W'(1))); // R1
  AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (match && !ccfg_q.per && !(|wr_half)) |=> $stable(tgt)); // R3
  AST_PER_ADVANCE: assert property (@(posedge clk) disable iff (!rst_s)
    (match && ccfg_q.per && !(|wr_half)) |=> (tgt == $past(tgt) + $past(per))); // R4
  AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_s)
    match |=> stat); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_s)
    (!ccfg_q.ien && !$past(ccfg_q.ien)) |-> !irq_o); // R6
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_o && ccfg_q.lvl && !bus_wr) |=> irq_o); // R7
  AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_s)
    (match && ccfg_q.ien && !ccfg_q.lvl && !bus_wr) |=> irq_o); // R8
  AST_ARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_s)
    (|wr_half) |=> !ccfg_q.arm); // R9
  AST_PERIOD_ONLY: assert property (@(posedge clk) disable iff (!rst_s)
    ((|wr_half) && !ld_tgt && !match) |=> $stable(tgt)); // R10
endmodule

bind evt_timer evt_tmr_chk #(.CNT_W(CNT_W), .HALVES(HALVES)) u_chk (
  .clk(clk), .rst_s(rst_s), .run_q(run_q), .ccfg_q(ccfg_q), .cnt(cnt),
  .tgt(tgt), .per(per), .match(match), .stat(stat), .ld_tgt(ld_tgt),
  .wr_half(wr_half), .bus_wr(bus_wr), .irq_o(irq_o)
);

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  evt_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // behavioural reference state
  logic [63:0] m_cnt, m_tgt, m_per;
  logic        m_run, m_stat, m_pulse, m_ien, m_lvl, m_per_mode, m_arm;

  function automatic logic m_irq();
    return m_lvl ? (m_stat && m_ien) : m_pulse;
  endfunction

  function automatic logic [31:0] m_read(input logic [5:0] a);
    case (a)
      6'h04: return {31'b0, m_run};
      6'h08: return {31'b0, m_stat};
      6'h10: return {28'b0, m_arm, m_per_mode, m_lvl, m_ien};
      6'h18: return m_cnt[31:0];
      6'h1C: return m_cnt[63:32];
      6'h20: return m_tgt[31:0];
      6'h24: return m_tgt[63:32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_tgt = '0; m_per = '0; m_run = 0; m_stat = 0;
      m_pulse = 0; m_ien = 0; m_lvl = 0; m_per_mode = 0; m_arm = 0;
    end else begin
      logic hit, wlo, whi, load;
      logic [63:0] t_new;
      hit   = m_run && (m_cnt == m_tgt);
      wlo   = bus_wr && bus_addr == 6'h20;
      whi   = bus_wr && bus_addr == 6'h24;
      load  = (wlo || whi) && (m_arm || !m_per_mode);
      t_new = m_tgt;
      if (load) begin
        if (wlo) t_new[31:0]  = bus_wdata;
        if (whi) t_new[63:32] = bus_wdata;
      end else if (hit && m_per_mode) begin
        t_new = m_tgt + m_per;
      end
      if (wlo) m_per[31:0]  = bus_wdata;
      if (whi) m_per[63:32] = bus_wdata;
      m_tgt   = t_new;
      m_pulse = hit && m_ien && !m_lvl;
      if (hit) m_stat = 1;
      else if (bus_wr && bus_addr == 6'h08 && bus_wdata[0]) m_stat = 0;
      if (m_run) m_cnt = m_cnt + 64'd1;
      if (bus_wr && bus_addr == 6'h04) m_run = bus_wdata[0];
      if (bus_wr && bus_addr == 6'h10) begin
        {m_arm, m_per_mode, m_lvl, m_ien} = bus_wdata[3:0];
      end else if (wlo || whi) begin
        m_arm = 0;
      end
    end
  end

  // irq_o compared on every falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (irq_o !== m_irq()) begin
        errors++;
        $display("FAIL %s irq_o actual %0b expected %0b at %0t",
                 m_ien ? (m_lvl ? "R7" : "R8") : "R6", irq_o, m_irq(), $time);
      end
    end
  end

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h04: return "R1";
      6'h08: return "R5";
      6'h10: return "R9";
      6'h18, 6'h1C: return "R2";
      default: return "R4";
    endcase
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== m_read(a)) begin
      errors++;
      $display("FAIL %s read 0x%0h actual %0h expected %0h",
               tag_of(a), a, bus_rdata, m_read(a));
    end
  endtask

  task automatic expect_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_all();
    rd(6'h04); rd(6'h08); rd(6'h10); rd(6'h18); rd(6'h1C); rd(6'h20); rd(6'h24);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    // R2 reset state
    read_all();
    // R3 one-shot level channel, target 25
    wr(6'h10, 32'h3);
    wr(6'h20, 32'd25);
    wr(6'h24, 32'd0);
    rd(6'h20);
    expect_val("R9", bus_rdata, 32'd25);
    wr(6'h04, 32'h1);
    idle(40);
    rd(6'h08);
    expect_val("R7", {31'b0, irq_o}, 32'h1);
    // R5 writing 0 leaves status, writing 1 clears it
    wr(6'h08, 32'h0);
    rd(6'h08);
    expect_val("R5", bus_rdata, 32'h1);
    wr(6'h08, 32'h1);
    rd(6'h08);
    expect_val("R5", bus_rdata, 32'h0);
    idle(10);
    rd(6'h08);
    expect_val("R3", bus_rdata, 32'h0);
    rd(6'h20);
    // R1 stop and restart
    wr(6'h04, 32'h0);
    rd(6'h18);
    c0 = bus_rdata;
    idle(6);
    rd(6'h18);
    expect_val("R1", bus_rdata, c0);
    wr(6'h04, 32'h1);
    rd(6'h18);
    // R4 periodic edge channel, target 200 then period 7
    wr(6'h10, 32'hD);
    wr(6'h20, 32'd200);
    wr(6'h10, 32'hD);
    wr(6'h24, 32'd0);
    wr(6'h20, 32'd7);
    rd(6'h20);
    expect_val("R10", bus_rdata, 32'd200);
    rd(6'h10);
    idle(120);
    rd(6'h20); rd(6'h24); rd(6'h08);
    // R6 interrupt disabled, status still set by matches
    wr(6'h08, 32'h1);
    wr(6'h10, 32'h4);
    idle(20);
    rd(6'h08);
    expect_val("R5", bus_rdata, 32'h1);
    // period 1: a match on every cycle with edge signalling
    wr(6'h20, 32'd1);
    wr(6'h10, 32'h5);
    idle(20);
    rd(6'h20);
    // R7 periodic level, then a clear beside a match
    wr(6'h10, 32'h7);
    idle(5);
    wr(6'h08, 32'h1);
    rd(6'h08);
    // R9 far target in the high half: no further match
    wr(6'h10, 32'hB);
    wr(6'h24, 32'd5);
    rd(6'h10);
    expect_val("R9", bus_rdata, 32'hB & 32'h7);
    wr(6'h08, 32'h1);
    idle(20);
    rd(6'h08);
    expect_val("R3", bus_rdata, 32'h0);
    read_all();
    idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule